// File: doc/BRIEF.md
# Segment Write Guard

This block sits between a processor's memory write strobe and the RAM write-enable. The RAM is divided into fixed 64 KB segments, and each segment has its own protect bit. A set bit makes the segment read-only. Because every segment is controlled on its own, a protected region can be any whole number of segments. It need not be a power of two. A typical setup keeps a 4 MB RAM with system code in the first 256 KB and system data in the next 256 KB. Software can then protect only the code segments, or both the code and the data segments.

The protect lookup is purely combinational from the address and the write request. It therefore adds no wait cycle to a memory access. A blocked write never reaches the RAM. A policy bit selects between two behaviours. In silent mode the blocked write is only dropped. In reporting mode the blocked write is also recorded: a sticky violation flag and the offending segment number are latched, and an interrupt request is raised until software clears the flag. There is also a simpler mode that replaces the table with an address mask and protects a power-of-two sized region starting at segment 0. All settings are held in a small byte-wide I/O register file.

Top module: `wp_seg_guard`

## Requirements
- R1: After reset every table bit, the control byte, the mask byte and the violation state are zero. The interrupt is low, and memWe follows memWrReq for every address.
- R2: The segment number is memAddr[21:16]. I/O offset g (0 to 7) holds the protect bits of segments 8g to 8g+7, with bit b governing segment 8g+b. A value of 1 means protected. Each offset reads back what was last written to it.
- R3: In the same cycle as the request, memWe equals memWrReq for an unprotected segment and is 0 for a protected segment, in both policies.
- R4: An I/O write takes effect from the next clock edge. A memory write issued in the same cycle as the register write is judged with the old settings.
- R5: Offset 8 is the control byte. Bit 0 selects the policy (0 = silent, 1 = reporting) and bit 1 enables mask mode. The other bits read as 0. Offset 9 holds a 6-bit mask in bits 5:0. In mask mode, segment s is protected exactly when (s AND NOT mask) is 0, and the table is ignored.
- R6: In silent policy a blocked write neither sets the violation flag nor raises the interrupt.
- R7: In reporting policy a blocked write sets the flag (offset 10 bit 7) and stores the segment number in offset 10 bits 5:0 at the clock edge. The interrupt output then equals the flag ANDed with the policy bit.
- R8: Once the flag is set, it and the stored segment are held until an offset-10 write with bit 7 = 1. Later violations do not overwrite them, and an offset-10 write with bit 7 = 0 has no effect.
- R9: If a clearing write and a new violation occur in the same cycle, the new violation is latched.
- R10: Offsets 11 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | input | 22 | Byte address of the memory access |
| memWrReq | input | 1 | Processor memory write request |
| memWe | output | 1 | Gated write-enable to the RAM |
| ioWrEn | input | 1 | Register file write strobe |
| ioAddr | input | 4 | Register file offset |
| ioWrData | input | 8 | Register write data |
| ioRdData | output | 8 | Register read data for ioAddr, combinational |
| violIrq | output | 1 | Write violation interrupt request |

## Verification
The bench builds the block with its default parameters: a 22-bit address, 64 segments and 8 table bytes. With these values, random addresses spread across every table byte and every bit position. The mask width of 6 bits also lets every power-of-two region, from 1 to 64 segments, be reached. Directed cases cover the 256 KB code and data layout at segment boundaries, a protected set that is not a power of two, and same-cycle clear against a new violation.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef struct packed {
    logic tableWr;
    logic ctrlWr;
    logic maskWr;
    logic clrViol;
    logic latchViol;
  } wpStrobe_t;
endpackage

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int IO_AW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioWrEn,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic             clrBit,
  input  logic             memWrReq,
  input  logic             protHit,
  input  logic             irqPolicy,
  output wpStrobe_t        strb,
  output logic             memWe
);
  localparam logic [IO_AW-1:0] CTRL_OFS = IO_AW'(NUM_GROUPS);
  localparam logic [IO_AW-1:0] MASK_OFS = IO_AW'(NUM_GROUPS + 1);
  localparam logic [IO_AW-1:0] STAT_OFS = IO_AW'(NUM_GROUPS + 2);

  always_comb begin
    strb.tableWr   = ioWrEn && (ioAddr < CTRL_OFS);
    strb.ctrlWr    = ioWrEn && (ioAddr == CTRL_OFS);
    strb.maskWr    = ioWrEn && (ioAddr == MASK_OFS);
    strb.clrViol   = ioWrEn && (ioAddr == STAT_OFS) && clrBit;
    strb.latchViol = memWrReq && protHit && irqPolicy;
    memWe          = memWrReq && !protHit;
  end

  // R3: the RAM never sees a write that the processor did not request
  p_we_needs_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memWrReq);
  // R10: at most one register strobe fires per cycle
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.tableWr, strb.ctrlWr, strb.maskWr, strb.clrViol}));
endmodule

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int SEG_W = 6,
  parameter int IO_AW = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wpStrobe_t         strb,
  input  logic [IO_AW-1:0]  ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic [SEG_W-1:0]  segIdx,
  output logic              protHit,
  output logic              irqPolicy,
  output logic              violIrq,
  output logic [DATA_W-1:0] ioRdData
);
  localparam int NUM_SEG = NUM_GROUPS * DATA_W;
  localparam int GS_W = $clog2(NUM_GROUPS);
  localparam logic [IO_AW-1:0] CTRL_OFS = IO_AW'(NUM_GROUPS);
  localparam logic [IO_AW-1:0] MASK_OFS = IO_AW'(NUM_GROUPS + 1);
  localparam logic [IO_AW-1:0] STAT_OFS = IO_AW'(NUM_GROUPS + 2);

  logic [NUM_GROUPS-1:0][DATA_W-1:0] protTable;
  logic [NUM_SEG-1:0] tableFlat;
  logic [1:0] ctrlReg;
  logic [SEG_W-1:0] maskReg;
  logic violFlag;
  logic [SEG_W-1:0] faultSeg;
  logic maskMode, maskHit;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) protTable[g] <= '0;
      else if (strb.tableWr && ioAddr[GS_W-1:0] == GS_W'(g)) protTable[g] <= ioWrData;
    end
    assign tableFlat[g*DATA_W +: DATA_W] = protTable[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      maskReg <= '0;
    end else begin
      if (strb.ctrlWr) ctrlReg <= ioWrData[1:0];
      if (strb.maskWr) maskReg <= ioWrData[SEG_W-1:0];
    end
  end

  assign irqPolicy = ctrlReg[0];
  assign maskMode  = ctrlReg[1];
  assign maskHit   = ((segIdx & ~maskReg) == '0);
  assign protHit   = maskMode ? maskHit : tableFlat[segIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violFlag <= 1'b0;
      faultSeg <= '0;
    end else if (strb.latchViol && (!violFlag || strb.clrViol)) begin
      violFlag <= 1'b1;
      faultSeg <= segIdx;
    end else if (strb.clrViol) begin
      violFlag <= 1'b0;
    end
  end

  assign violIrq = violFlag && irqPolicy;

  always_comb begin
    ioRdData = '0;
    if (ioAddr < CTRL_OFS) ioRdData = protTable[ioAddr[GS_W-1:0]];
    else if (ioAddr == CTRL_OFS) ioRdData = DATA_W'(ctrlReg);
    else if (ioAddr == MASK_OFS) ioRdData = DATA_W'(maskReg);
    else if (ioAddr == STAT_OFS) begin
      ioRdData[DATA_W-1] = violFlag;
      ioRdData[SEG_W-1:0] = faultSeg;
    end
  end

  // R8: flag and segment hold until a clearing write
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    violFlag && !strb.clrViol |=> violFlag);
  p_seg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    violFlag && !strb.clrViol |=> $stable(faultSeg));
  // R7: a first violation records its segment
  p_seg_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchViol && !violFlag |=> violFlag && faultSeg == $past(segIdx));
  // R6: silent policy never raises the flag
  p_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    !irqPolicy && !violFlag |=> !violFlag);
endmodule

// File: rtl/wp_seg_guard.sv
module wp_seg_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int SEG_SHIFT = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memWrReq,
  output logic              memWe,
  input  logic              ioWrEn,
  input  logic [3:0]        ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  output logic              violIrq
);
  localparam int SEG_W = ADDR_W - SEG_SHIFT;
  localparam int NUM_GROUPS = (1 << SEG_W) / DATA_W;
  localparam int IO_AW = 4;

  wpStrobe_t strb;
  logic protHit, irqPolicy;
  logic [SEG_W-1:0] segIdx;

  assign segIdx = memAddr[ADDR_W-1:SEG_SHIFT];

  wp_ctrl #(.NUM_GROUPS(NUM_GROUPS), .IO_AW(IO_AW)) uCtrl (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioAddr(ioAddr),
    .clrBit(ioWrData[DATA_W-1]), .memWrReq(memWrReq), .protHit(protHit),
    .irqPolicy(irqPolicy), .strb(strb), .memWe(memWe)
  );

  wp_datapath #(.NUM_GROUPS(NUM_GROUPS), .SEG_W(SEG_W), .IO_AW(IO_AW), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .segIdx(segIdx), .protHit(protHit), .irqPolicy(irqPolicy),
    .violIrq(violIrq), .ioRdData(ioRdData)
  );
endmodule

// File: tb/tb_wp_seg_guard.sv
module tb_wp_seg_guard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [21:0] memAddr = '0;
  logic memWrReq = 1'b0;
  logic memWe;
  logic ioWrEn = 1'b0;
  logic [3:0] ioAddr = '0;
  logic [7:0] ioWrData = '0;
  logic [7:0] ioRdData;
  logic violIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] mTable [8];
  logic [1:0] mCtrl;
  logic [5:0] mMask;
  logic mFlag;
  logic [5:0] mSeg;

  always #10 clk = ~clk;

  wp_seg_guard dut (.*);

  function automatic bit isProt(input logic [5:0] s);
    if (mCtrl[1]) return ((s & ~mMask) == 6'd0);
    return mTable[s[5:3]][s[2:0]];
  endfunction

  function automatic logic [7:0] expRead(input logic [3:0] a);
    if (a < 4'd8) return mTable[a[2:0]];
    if (a == 4'd8) return {6'd0, mCtrl};
    if (a == 4'd9) return {2'd0, mMask};
    if (a == 4'd10) return {mFlag, 1'b0, mSeg};
    return 8'd0;
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive inputs, check combinational outputs, then advance the model
  task automatic step(input string tag, input logic wr, input logic [21:0] addr,
                      input logic io, input logic [3:0] ia, input logic [7:0] id);
    logic [5:0] s;
    bit viol, clr;
    @(negedge clk);
    memWrReq = wr; memAddr = addr; ioWrEn = io; ioAddr = ia; ioWrData = id;
    #5;
    s = addr[21:16];
    check(tag, "memWe", {7'd0, memWe}, {7'd0, wr & ~isProt(s)});
    check(tag, "violIrq", {7'd0, violIrq}, {7'd0, mFlag & mCtrl[0]});
    check(tag, "ioRdData", ioRdData, expRead(ia));
    @(posedge clk);
    viol = wr && isProt(s) && mCtrl[0];
    clr = io && ia == 4'd10 && id[7];
    if (io) begin
      if (ia < 4'd8) mTable[ia[2:0]] = id;
      else if (ia == 4'd8) mCtrl = id[1:0];
      else if (ia == 4'd9) mMask = id[5:0];
    end
    if (viol && (!mFlag || clr)) begin mFlag = 1'b1; mSeg = s; end
    else if (clr) mFlag = 1'b0;
  endtask

  task automatic ioW(input string tag, input logic [3:0] a, input logic [7:0] d);
    step(tag, 1'b0, 22'd0, 1'b1, a, d);
  endtask

  task automatic memW(input string tag, input logic [21:0] a, input logic [3:0] ra);
    step(tag, 1'b1, a, 1'b0, ra, 8'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mTable[i] = 8'd0;
    mCtrl = 2'd0; mMask = 6'd0; mFlag = 1'b0; mSeg = 6'd0;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1: reset readback of every offset, writes pass
    for (int a = 0; a < 16; a++) step("R1", 1'b0, 22'd0, 1'b0, 4'(a), 8'd0);
    for (int s = 0; s < 64; s += 9) memW("R1", {6'(s), 16'h1234}, 4'd10);

    // R2: protect code segments 0-3 then code and data 0-7
    ioW("R2", 4'd0, 8'h0F);
    memW("R2", 22'h03FFFF, 4'd0);
    memW("R2", 22'h040000, 4'd0);
    ioW("R2", 4'd0, 8'hFF);
    memW("R2", 22'h07FFFF, 4'd0);
    memW("R2", 22'h080000, 4'd1);
    // non-power-of-two set: segments 9,10,11 and 40
    ioW("R2", 4'd1, 8'h0E);
    ioW("R2", 4'd5, 8'h01);
    memW("R3", 22'h0A0000, 4'd1);
    memW("R3", 22'h0C0000, 4'd1);
    memW("R3", 22'h280000, 4'd5);
    memW("R3", 22'h290000, 4'd5);

    // R4: register write and memory write in the same cycle use old state
    step("R4", 1'b1, 22'h100000, 1'b1, 4'd2, 8'h01);
    memW("R4", 22'h100000, 4'd2);

    // R6: silent policy - blocked, no flag
    memW("R6", 22'h000000, 4'd10);
    step("R6", 1'b0, 22'd0, 1'b0, 4'd10, 8'd0);

    // R7: reporting policy
    ioW("R7", 4'd8, 8'h01);
    memW("R7", 22'h0B1234, 4'd10);
    step("R7", 1'b0, 22'd0, 1'b0, 4'd10, 8'd0);
    // R8: later violation ignored, bit7=0 write ignored
    memW("R8", 22'h020000, 4'd10);
    ioW("R8", 4'd10, 8'h7F);
    step("R8", 1'b0, 22'd0, 1'b0, 4'd10, 8'd0);
    ioW("R8", 4'd10, 8'h80);
    step("R8", 1'b0, 22'd0, 1'b0, 4'd10, 8'd0);
    // R9: clear and violation together
    memW("R9", 22'h050000, 4'd10);
    step("R9", 1'b1, 22'h280000, 1'b1, 4'd10, 8'h80);
    step("R9", 1'b0, 22'd0, 1'b0, 4'd10, 8'd0);
    ioW("R9", 4'd10, 8'h80);

    // R5: mask mode, region of 4 segments, table ignored
    ioW("R5", 4'd9, 8'h03);
    ioW("R5", 4'd8, 8'hFF);
    step("R5", 1'b0, 22'd0, 1'b0, 4'd8, 8'd0);
    memW("R5", 22'h03FFFF, 4'd9);
    memW("R5", 22'h040000, 4'd9);
    memW("R5", 22'h280000, 4'd9);
    ioW("R5", 4'd9, 8'h3F);
    memW("R5", 22'h3FFFFF, 4'd9);
    ioW("R5", 4'd10, 8'h80);
    ioW("R5", 4'd8, 8'h00);

    // R10: unused offsets
    for (int a = 11; a < 16; a++) ioW("R10", 4'(a), 8'hFF);
    for (int a = 0; a < 16; a++) step("R10", 1'b0, 22'd0, 1'b0, 4'(a), 8'd0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      logic [3:0] ra = 4'($urandom_range(0, 15));
      if (k < 5) memW("R3", 22'($urandom), ra);
      else if (k < 7) ioW("R2", 4'($urandom_range(0, 7)), 8'($urandom));
      else if (k == 7) ioW("R5", 4'($urandom_range(8, 9)), 8'($urandom));
      else if (k == 8) ioW("R8", 4'd10, 8'($urandom));
      else step("R9", 1'b1, 22'($urandom), 1'b1, 4'd10, 8'($urandom));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule